// File: doc/BRIEF.md
# Accelerator memory port to Wishbone classic master bridge

This block sits between an accelerator's simple memory-request port and a Wishbone classic bus. Each read or write request becomes exactly one standard single bus cycle. The bridge turns the request's access width, which is given as a count of bits, and the low address bits into byte-lane selects. It places write data on the matching lanes and moves read data from those lanes down to bit 0. When the cycle is acknowledged, the bridge reports completion with a one-cycle data-ready pulse.

The request side follows valid/ready rules. The read strobe or the write strobe acts as valid, and `req_ready` is high only while the bridge is idle. A request presented while `req_ready` is low is not queued: it is ignored. The requester keeps it asserted until it is taken. The response side has no back-pressure. `rsp_valid` pulses for one cycle whether or not the requester is watching. `rsp_data` holds the last read result until another read completes.

Top module: `accmem_wb_bridge`

## Requirements
- R1: After reset, `wb_cyc_o`, `wb_stb_o` and `rsp_valid` are low, `req_ready` is high and `rsp_data` is zero.
- R2: While idle, a high `req_rd` or `req_wr` is accepted at the clock edge. In the following cycle `wb_cyc_o` and `wb_stb_o` are high, `wb_adr_o` equals the request address with its two low bits cleared, and `wb_we_o` is high for a write.
- R3: While a cycle is open and `wb_ack_i` is low, `wb_cyc_o` and `wb_stb_o` stay high, address, select, data and write enable stay unchanged, `req_ready` is low and new requests are ignored.
- R4: When `wb_ack_i` is sampled high during a cycle, `wb_cyc_o` and `wb_stb_o` are low in the next cycle and `rsp_valid` is high for exactly that one cycle. An ack sampled while idle has no effect.
- R5: The width decodes as follows: 8 selects one lane, 16 selects two lanes, 32 selects all four lanes (`wb_sel_o` = 0xF), and any other count is treated as a full 32-bit access.
- R6: The selected lanes start at the address low bits rounded down to the width's alignment. An 8-bit access at offset k gives select 1<<k. A 16-bit access gives 0x3 when address bit 1 is 0 and 0xC when it is 1.
- R7: On a write, the low bits of `req_wdata` that fit the width appear on the selected lanes of `wb_dat_o`, and the lanes that are not selected are zero.
- R8: On a read, the selected lanes of `wb_dat_i` are captured on the ack, shifted down to bit 0 and zero-extended into `rsp_data`. `rsp_data` holds that value, and a write completion leaves it unchanged.
- R9: A request with both strobes high is performed as a write.
- R10: `req_ready` is high again in the cycle that carries `rsp_valid`, so there is at least one cycle with `wb_cyc_o` low between two bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data, right-aligned |
| req_rd | input | 1 | Read request (valid) |
| req_wr | input | 1 | Write request (valid) |
| req_bits | input | SIZE_W | Access width as a bit count |
| req_ready | output | 1 | Bridge idle, request will be taken |
| rsp_data | output | DATA_W | Read result, right-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| wb_adr_o | output | ADDR_W | Bus address, word aligned |
| wb_dat_o | output | DATA_W | Bus write data on byte lanes |
| wb_dat_i | input | DATA_W | Bus read data |
| wb_sel_o | output | DATA_W/8 | Byte-lane selects |
| wb_we_o | output | 1 | Bus write enable |
| wb_cyc_o | output | 1 | Bus cycle in progress |
| wb_stb_o | output | 1 | Bus strobe |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
The hardest case to reach from the ports is a request that arrives while a cycle is held open by a slow acknowledge. Such a request must neither disturb the open cycle nor be taken later. The bench model of the slave delays the ack by zero to two cycles. During every wait cycle the bench presents a conflicting read to a different address, then checks that the bus outputs are unchanged and that nothing is started once the ack lands. It sweeps every width code, including illegal ones, against every address offset in both directions. This exposes each select pattern, each data-lane shift and each read alignment.

// File: rtl/accwb_pkg.sv
package accwb_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic {ST_IDLE, ST_BUSY} bus_state_t;
endpackage

// File: rtl/accwb_lane_map.sv
module accwb_lane_map #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 6,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [SIZE_W-1:0] bits_i,
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NB-1:0]     sel_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [DATA_W-1:0] keep_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [SIZE_W-4:0] bytes_req;
  logic [OFF_W:0]    lg;
  logic [NB-1:0]     base_sel;
  logic [OFF_W-1:0]  low_mask;

  assign bytes_req = bits_i[SIZE_W-1:3];

  // log2 of the lane count; unknown widths fall back to full width
  always_comb begin
    lg = (OFF_W+1)'(OFF_W);
    for (int k = 0; k < OFF_W; k++) begin
      if (bits_i[2:0] == 3'b000 && bytes_req == (SIZE_W-3)'(1 << k))
        lg = (OFF_W+1)'(k);
    end
  end

  always_comb begin
    for (int i = 0; i < NB; i++) base_sel[i] = (i < (1 << lg));
  end

  assign low_mask = OFF_W'((1 << lg) - 1);
  assign off_o    = addr_lo_i & ~low_mask;
  assign sel_o    = base_sel << off_o;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_keep
      assign keep_o[gi] = base_sel[gi / accwb_pkg::BYTE_W];
    end
  endgenerate

  assign wdata_o = (wdata_i & keep_o) << {off_o, 3'b000};
endmodule

// File: rtl/accwb_seq.sv
module accwb_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-OFF_W-1:0] word_i,
  input  logic [NB-1:0]           sel_i,
  input  logic [DATA_W-1:0]       wdat_i,
  input  logic                    ack_i,
  output logic                    ready_o,
  output logic                    accept_o,
  output logic                    take_o,
  output logic                    cyc_o,
  output logic                    stb_o,
  output logic [ADDR_W-1:0]       adr_o,
  output logic [NB-1:0]           sel_o,
  output logic [DATA_W-1:0]       dat_o,
  output logic                    we_o,
  output logic                    done_o
);
  import accwb_pkg::*;
  bus_state_t state;

  assign ready_o  = (state == ST_IDLE);
  assign accept_o = ready_o && (rd_i || wr_i);
  assign cyc_o    = (state == ST_BUSY);
  assign stb_o    = cyc_o;
  assign take_o   = cyc_o && ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      adr_o  <= '0;
      sel_o  <= '0;
      dat_o  <= '0;
      we_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= take_o;
      if (accept_o) begin
        state <= ST_BUSY;
        adr_o <= {word_i, {OFF_W{1'b0}}};
        sel_o <= sel_i;
        dat_o <= wdat_i;
        we_o  <= wr_i;
      end else if (take_o) begin
        state <= ST_IDLE;
      end
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_o && !ack_i |=> cyc_o);
  p_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_o && !ack_i |=> $stable(adr_o) && $stable(sel_o) && $stable(dat_o) && $stable(we_o));
  p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_o && ack_i |=> !cyc_o && done_o);
  p_done_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(cyc_o && ack_i));
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ready_o);
  p_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_o |-> ($countones(sel_o) == 1 || $countones(sel_o) == 2 || $countones(sel_o) == NB));
endmodule

// File: rtl/accwb_rd_align.sv
module accwb_rd_align #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] keep_i,
  input  logic              take_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] data_o
);
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] keep_q;
  logic              cap;

  assign cap = take_i && !we_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      keep_q <= '0;
      data_o <= '0;
    end else begin
      if (accept_i) begin
        off_q  <= off_i;
        keep_q <= keep_i;
      end
      if (cap) data_o <= (bus_i >> {off_q, 3'b000}) & keep_q;
    end
  end

  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(data_o));
endmodule

// File: rtl/accmem_wb_bridge.sv
module accmem_wb_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = $clog2(DATA_W) + 1,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [SIZE_W-1:0] req_bits,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [DATA_W-1:0] wb_dat_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [NB-1:0]     wb_sel_o,
  output logic              wb_we_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  input  logic              wb_ack_i
);
  logic [NB-1:0]     lane_sel;
  logic [OFF_W-1:0]  lane_off;
  logic [DATA_W-1:0] lane_keep;
  logic [DATA_W-1:0] lane_wdat;
  logic              accept;
  logic              take;

  accwb_lane_map #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_map (
    .bits_i    (req_bits),
    .addr_lo_i (req_addr[OFF_W-1:0]),
    .wdata_i   (req_wdata),
    .sel_o     (lane_sel),
    .off_o     (lane_off),
    .keep_o    (lane_keep),
    .wdata_o   (lane_wdat)
  );

  accwb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (req_rd),
    .wr_i     (req_wr),
    .word_i   (req_addr[ADDR_W-1:OFF_W]),
    .sel_i    (lane_sel),
    .wdat_i   (lane_wdat),
    .ack_i    (wb_ack_i),
    .ready_o  (req_ready),
    .accept_o (accept),
    .take_o   (take),
    .cyc_o    (wb_cyc_o),
    .stb_o    (wb_stb_o),
    .adr_o    (wb_adr_o),
    .sel_o    (wb_sel_o),
    .dat_o    (wb_dat_o),
    .we_o     (wb_we_o),
    .done_o   (rsp_valid)
  );

  accwb_rd_align #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .off_i    (lane_off),
    .keep_i   (lane_keep),
    .take_i   (take),
    .we_i     (wb_we_o),
    .bus_i    (wb_dat_i),
    .data_o   (rsp_data)
  );
endmodule

// File: tb/accmem_wb_bridge_test.sv
module accmem_wb_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_rd = 1'b0;
  logic        req_wr = 1'b0;
  logic [5:0]  req_bits = '0;
  logic        req_ready;
  logic [31:0] rsp_data;
  logic        rsp_valid;
  logic [31:0] wb_adr_o;
  logic [31:0] wb_dat_o;
  logic [31:0] wb_dat_i = '0;
  logic [3:0]  wb_sel_o;
  logic        wb_we_o;
  logic        wb_cyc_o;
  logic        wb_stb_o;
  logic        wb_ack_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  accmem_wb_bridge uut (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rd(req_rd), .req_wr(req_wr), .req_bits(req_bits), .req_ready(req_ready),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .wb_adr_o(wb_adr_o),
    .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_sel_o(wb_sel_o),
    .wb_we_o(wb_we_o), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
    .wb_ack_i(wb_ack_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input bit rd, input bit wr, input logic [31:0] addr, input logic [5:0] bits,
                      input logic [31:0] wd, input logic [31:0] bus_rd, input int dly);
    int w;
    int off;
    logic [3:0]  esel;
    logic [31:0] keep, ewd, erd, prev, sadr, sdat;
    logic [3:0]  ssel;
    w    = (bits == 6'd8) ? 1 : (bits == 6'd16) ? 2 : 4;
    off  = int'(addr[1:0]) & ~(w - 1);
    keep = (w == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * w)) - 32'd1);
    esel = 4'(((1 << w) - 1) << off);
    ewd  = (wd & keep) << (8 * off);
    erd  = (bus_rd >> (8 * off)) & keep;
    prev = rsp_data;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready when idle", 32'(req_ready), 32'd1);
    req_addr = addr; req_bits = bits; req_wdata = wd; req_rd = rd; req_wr = wr;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    chk(wb_cyc_o && wb_stb_o, "R2 cycle opened", {wb_cyc_o, wb_stb_o}, 32'd3);
    chk(wb_adr_o == {addr[31:2], 2'b00}, "R2 word address", wb_adr_o, {addr[31:2], 2'b00});
    chk(wb_we_o == wr, "R2 R9 write enable", 32'(wb_we_o), 32'(wr));
    chk(wb_sel_o == esel, "R5 R6 lane select", 32'(wb_sel_o), 32'(esel));
    if (wr) chk(wb_dat_o == ewd, "R7 write lanes", wb_dat_o, ewd);
    chk(req_ready == 1'b0, "R3 busy not ready", 32'(req_ready), 32'd0);
    sadr = wb_adr_o; ssel = wb_sel_o; sdat = wb_dat_o;
    for (int i = 0; i < dly; i++) begin
      req_rd = 1'b1; req_addr = ~addr; req_bits = 6'd8; req_wdata = ~wd;
      @(negedge clk);
      chk(wb_cyc_o && wb_adr_o == sadr && wb_sel_o == ssel && wb_dat_o == sdat && wb_we_o == wr,
          "R3 held during wait", wb_adr_o, sadr);
      chk(rsp_valid == 1'b0, "R4 no early valid", 32'(rsp_valid), 32'd0);
    end
    req_rd = 1'b0;
    wb_ack_i = 1'b1; wb_dat_i = bus_rd;
    @(negedge clk);
    wb_ack_i = 1'b0; wb_dat_i = 32'hDEAD_BEEF;
    chk(!wb_cyc_o && !wb_stb_o, "R4 cycle closed", {wb_cyc_o, wb_stb_o}, 32'd0);
    chk(rsp_valid == 1'b1, "R4 valid pulse", 32'(rsp_valid), 32'd1);
    chk(req_ready == 1'b1, "R10 ready with valid", 32'(req_ready), 32'd1);
    if (rd && !wr) chk(rsp_data == erd, "R8 read alignment", rsp_data, erd);
    else chk(rsp_data == prev, "R8 write keeps data", rsp_data, prev);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R4 pulse one cycle", 32'(rsp_valid), 32'd0);
    chk(wb_cyc_o == 1'b0, "R3 spurious request ignored", 32'(wb_cyc_o), 32'd0);
  endtask

  function automatic logic [5:0] bits_of(input int b);
    case (b)
      0: return 6'd8;
      1: return 6'd16;
      2: return 6'd32;
      3: return 6'd0;
      default: return 6'd24;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!wb_cyc_o && !wb_stb_o, "R1 bus idle", {wb_cyc_o, wb_stb_o}, 32'd0);
    chk(rsp_valid == 1'b0, "R1 no valid", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(rsp_data == 32'd0, "R1 data cleared", rsp_data, 32'd0);

    for (int b = 0; b < 5; b++)
      for (int o = 0; o < 4; o++)
        for (int d = 0; d < 3; d++)
          for (int dir = 0; dir < 2; dir++)
            xact(dir == 0, dir == 1, 32'h4000_0000 + 32'(b * 256 + d * 16 + o),
                 bits_of(b), 32'hA1B2_C3D4 ^ 32'(b * 3 + o), 32'h1122_3344 + 32'(o * 7 + b), d);

    // R9: both strobes high performs a write
    xact(1'b1, 1'b1, 32'h0000_0102, 6'd8, 32'h0000_005A, 32'hFFFF_FFFF, 1);

    // R4: ack while idle has no effect
    @(negedge clk);
    wb_ack_i = 1'b1;
    @(negedge clk);
    wb_ack_i = 1'b0;
    chk(rsp_valid == 1'b0, "R4 idle ack ignored", 32'(rsp_valid), 32'd0);
    chk(wb_cyc_o == 1'b0, "R4 idle ack no cycle", 32'(wb_cyc_o), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule